// File: doc/BRIEF.md
# SDRAM Burst Column Address Generator

This block produces the column address for each beat of an SDRAM burst. A controller pulses a start input together with the first column, a burst-length code and an ordering select. From the following cycle the block presents one column per clock with a valid flag, and it raises a last flag on the final beat of a fixed-length burst. Data movement and command encoding stay in the surrounding controller.

The burst length can be 1, 2, 4 or 8 beats, or full page. A full-page burst walks through the whole row modulo 2^COL_W (256 columns by default) and does not end until the controller stops it. Fixed-length bursts can be ordered sequentially or interleaved. In both orderings the address wraps inside the naturally aligned block of the burst length. A stop input ends any burst at once. A new start may arrive on any clock, including in the middle of a burst, and the block then restarts from the new column with the new settings.

Top module: `sdram_col_burst_gen`

## Requirements
- R1: After reset, and while reset is held, `valid_o` and `last_o` are low.
- R2: A `start_i` pulse at a clock edge makes `valid_o` high in the next cycle, with `col_o` equal to the sampled `start_col_i` (beat 0).
- R3: `blen_i` codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. `last_o` is high on the final beat only, and `valid_o` falls in the cycle after that beat.
- R4: With `ilv_i` = 0 and a fixed length BL, beat k has its low log2(BL) bits equal to (start low bits + k) mod BL. The upper column bits keep their start value.
- R5: With `ilv_i` = 1 and a fixed length BL, beat k has its low log2(BL) bits equal to the start low bits XOR k. The upper column bits keep their start value.
- R6: Any `blen_i` code with bit 2 set selects full page. Beat k is then (start + k) mod 2^COL_W, `last_o` stays low, and the burst keeps running until it is stopped.
- R7: A full-page burst always uses sequential order, whatever the value of `ilv_i`.
- R8: `stop_i` high during a burst, without `start_i`, makes `valid_o` and `last_o` low in the next cycle. When no burst is running, `stop_i` has no effect.
- R9: `start_i` high during a running burst restarts it from the new column, length and ordering. When `start_i` and `stop_i` are high together, the start takes priority.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Begin a burst (or restart one) at the next beat |
| start_col_i | input | COL_W | First column of the burst |
| blen_i | input | 3 | Burst length: 0..3 give 2^code beats, bit 2 set gives full page |
| ilv_i | input | 1 | 1 = interleaved order, 0 = sequential order |
| stop_i | input | 1 | Terminate the running burst |
| col_o | output | COL_W | Column address of the current beat |
| valid_o | output | 1 | `col_o` holds a beat |
| last_o | output | 1 | Final beat of a fixed-length burst |

## Verification
The assertions take `start_i` and `stop_i` to be sampled synchronously and assume nothing about how often they arrive. So the only condition they rely on is a clean reset at the start. They check a start-to-first-beat latency of exactly one cycle, termination on stop or on the last beat, and that a running burst continues until one of these events occurs. The stimulus changes inputs only on the falling clock edge and holds each start or stop pulse for exactly one cycle. It also uses overlapping start and stop pulses and restarts in mid-burst, which places every transition inside what the properties describe.

// File: rtl/sdram_burst_pkg.sv
package sdram_burst_pkg;

   // Width of the burst-length code
   localparam int BLEN_W = 3;

   // Bit 2 of the code selects a burst that runs until stopped
   function automatic logic is_page(input logic [BLEN_W-1:0] code);
      return code[2];
   endfunction

endpackage

// File: rtl/sdram_bl_decode.sv
module sdram_bl_decode
   import sdram_burst_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic [BLEN_W-1:0] blen_i,
   output logic [COL_W-1:0]  mask_o,
   output logic              page_o
);

   // Largest fixed burst length is 8 beats, so 3 mask bits
   localparam int FIX_BITS = 3;

   assign page_o = is_page(blen_i);

   for (genvar i = 0; i < COL_W; i++) begin : g_mask
      if (i < FIX_BITS) begin : g_low
         assign mask_o[i] = page_o | (blen_i[1:0] > 2'(i));
      end else begin : g_high
         assign mask_o[i] = page_o;
      end
   end

endmodule

// File: rtl/sdram_col_map.sv
module sdram_col_map #(
   parameter int COL_W  = 8,
   parameter bit ILV_EN = 1'b1
) (
   input  logic [COL_W-1:0] base_i,
   input  logic [COL_W-1:0] beat_i,
   input  logic [COL_W-1:0] mask_i,
   input  logic             ilv_i,
   input  logic             page_i,
   output logic [COL_W-1:0] col_o
);

   logic [COL_W-1:0] seq_low;
   logic [COL_W-1:0] low_sel;

   assign seq_low = base_i + beat_i;

   if (ILV_EN) begin : g_ilv
      logic [COL_W-1:0] ilv_low;
      assign ilv_low = base_i ^ beat_i;
      assign low_sel = (ilv_i && !page_i) ? ilv_low : seq_low;
   end else begin : g_seq
      logic unused_ok;
      assign unused_ok = ilv_i ^ page_i;
      assign low_sel   = seq_low;
   end

   assign col_o = (base_i & ~mask_i) | (low_sel & mask_i);

endmodule

// File: rtl/sdram_col_burst_gen.sv
module sdram_col_burst_gen
   import sdram_burst_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter bit ILV_EN = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start_i,
   input  logic [COL_W-1:0] start_col_i,
   input  logic [2:0]       blen_i,
   input  logic             ilv_i,
   input  logic             stop_i,
   output logic [COL_W-1:0] col_o,
   output logic             valid_o,
   output logic             last_o
);

   localparam int MIN_COL_W = 3;
   localparam int MAX_COL_W = 16;

   if (COL_W < MIN_COL_W || COL_W > MAX_COL_W) begin : g_bad_width
      $error("sdram_col_burst_gen: COL_W must lie in 3..16");
   end

   logic [COL_W-1:0] dec_mask;
   logic             dec_page;

   logic             act_q;
   logic [COL_W-1:0] base_q;
   logic [COL_W-1:0] beat_q;
   logic [COL_W-1:0] mask_q;
   logic             ilv_q;
   logic             page_q;
   logic             fin;

   sdram_bl_decode #(.COL_W(COL_W)) u_dec (
      .blen_i (blen_i),
      .mask_o (dec_mask),
      .page_o (dec_page)
   );

   sdram_col_map #(.COL_W(COL_W), .ILV_EN(ILV_EN)) u_map (
      .base_i (base_q),
      .beat_i (beat_q),
      .mask_i (mask_q),
      .ilv_i  (ilv_q),
      .page_i (page_q),
      .col_o  (col_o)
   );

   assign fin = act_q && !page_q && (beat_q == mask_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_q  <= 1'b0;
         base_q <= '0;
         beat_q <= '0;
         mask_q <= '0;
         ilv_q  <= 1'b0;
         page_q <= 1'b0;
      end else if (start_i) begin
         act_q  <= 1'b1;
         base_q <= start_col_i;
         beat_q <= '0;
         mask_q <= dec_mask;
         ilv_q  <= ilv_i;
         page_q <= dec_page;
      end else if (act_q) begin
         if (stop_i || fin) begin
            act_q <= 1'b0;
         end else begin
            beat_q <= beat_q + 1'b1;
         end
      end
   end

   assign valid_o = act_q;
   assign last_o  = fin;

endmodule

// File: rtl/sdram_col_burst_gen_chk.sv
module sdram_col_burst_gen_chk #(
   parameter int COL_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start_i,
   input logic [COL_W-1:0] start_col_i,
   input logic             stop_i,
   input logic [COL_W-1:0] col_o,
   input logic             valid_o,
   input logic             last_o
);

   // R1
   reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !valid_o && !last_o);

   // R2
   first_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_i |=> valid_o && col_o == $past(start_col_i));

   // R3
   last_in_burst_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o |-> valid_o);

   // R3
   end_after_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      last_o && !start_i |=> !valid_o);

   // R8
   stop_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
      stop_i && !start_i |=> !valid_o && !last_o);

   // R6
   burst_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      valid_o && !last_o && !stop_i |=> valid_o);

endmodule

bind sdram_col_burst_gen sdram_col_burst_gen_chk #(.COL_W(COL_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .start_i     (start_i),
   .start_col_i (start_col_i),
   .stop_i      (stop_i),
   .col_o       (col_o),
   .valid_o     (valid_o),
   .last_o      (last_o)
);

// File: tb/sdram_col_burst_gen_test.sv
`timescale 1ns/1ps
module sdram_col_burst_gen_test;

   localparam int COL_W = 8;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             start_i = 1'b0;
   logic [COL_W-1:0] start_col_i = '0;
   logic [2:0]       blen_i = '0;
   logic             ilv_i = 1'b0;
   logic             stop_i = 1'b0;
   logic [COL_W-1:0] col_o;
   logic             valid_o;
   logic             last_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   sdram_col_burst_gen #(.COL_W(COL_W)) uut (
      .clk (clk), .rst_n (rst_n), .start_i (start_i), .start_col_i (start_col_i),
      .blen_i (blen_i), .ilv_i (ilv_i), .stop_i (stop_i),
      .col_o (col_o), .valid_o (valid_o), .last_o (last_o)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int exp_col(input int base, input int code, input bit ilv, input int k);
      int m;
      int lo;
      if (code >= 4) return (base + k) % (1 << COL_W);
      m  = (1 << code) - 1;
      lo = ilv ? ((base & m) ^ k) : (((base & m) + k) & m);
      return (base & ~m & ((1 << COL_W) - 1)) | lo;
   endfunction

   task automatic kick(input int col, input int code, input bit ilv, input bit stp);
      @(negedge clk);
      start_i = 1'b1; start_col_i = COL_W'(col); blen_i = 3'(code); ilv_i = ilv; stop_i = stp;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
   endtask

   task automatic expect_beats(input string req, input int base, input int code, input bit ilv,
                               input int count);
      int n;
      n = (code >= 4) ? 0 : (1 << code);
      for (int k = 0; k < count; k++) begin
         chk(req, "valid", int'(valid_o), 1);
         chk(req, "col", int'(col_o), exp_col(base, code, ilv, k));
         chk(req, "last", int'(last_o), int'(n != 0 && k == n - 1));
         @(negedge clk);
      end
   endtask

   task automatic expect_idle(input string req);
      chk(req, "valid idle", int'(valid_o), 0);
      chk(req, "last idle", int'(last_o), 0);
   endtask

   task automatic t_reset();
      @(negedge clk);
      expect_idle("R1");
      rst_n = 1'b1;
      @(negedge clk);
      expect_idle("R1");
   endtask

   task automatic t_lengths();
      for (int c = 0; c < 4; c++) begin
         kick(8'h6B, c, 1'b0, 1'b0);
         expect_beats("R3", 8'h6B, c, 1'b0, 1 << c);
         expect_idle("R3");
      end
   endtask

   task automatic t_sequential();
      kick(8'h35, 3, 1'b0, 1'b0);
      chk("R2", "first col", int'(col_o), 8'h35);
      expect_beats("R4", 8'h35, 3, 1'b0, 8);
      expect_idle("R4");
      kick(8'hC3, 2, 1'b0, 1'b0);
      expect_beats("R4", 8'hC3, 2, 1'b0, 4);
   endtask

   task automatic t_interleaved();
      kick(8'h35, 3, 1'b1, 1'b0);
      expect_beats("R5", 8'h35, 3, 1'b1, 8);
      expect_idle("R5");
      kick(8'hD1, 1, 1'b1, 1'b0);
      expect_beats("R5", 8'hD1, 1, 1'b1, 2);
   endtask

   task automatic t_full_page();
      kick(8'hFC, 4, 1'b0, 1'b0);
      expect_beats("R6", 8'hFC, 4, 1'b0, 12);
      @(negedge clk);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      expect_idle("R6");
      kick(8'h3E, 7, 1'b1, 1'b0);
      expect_beats("R7", 8'h3E, 4, 1'b0, 6);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      expect_idle("R7");
   endtask

   task automatic t_stop();
      kick(8'h20, 3, 1'b0, 1'b0);
      expect_beats("R8", 8'h20, 3, 1'b0, 3);
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      expect_idle("R8");
      stop_i = 1'b1;
      @(negedge clk);
      stop_i = 1'b0;
      expect_idle("R8");
      kick(8'h90, 1, 1'b0, 1'b0);
      expect_beats("R8", 8'h90, 1, 1'b0, 2);
      expect_idle("R8");
   endtask

   task automatic t_restart();
      kick(8'h10, 3, 1'b0, 1'b0);
      expect_beats("R9", 8'h10, 3, 1'b0, 2);
      start_i = 1'b1; start_col_i = 8'h47; blen_i = 3'd2; ilv_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      expect_beats("R9", 8'h47, 2, 1'b1, 4);
      expect_idle("R9");
      kick(8'h55, 3, 1'b0, 1'b0);
      expect_beats("R9", 8'h55, 3, 1'b0, 1);
      start_i = 1'b1; stop_i = 1'b1; start_col_i = 8'h80; blen_i = 3'd1; ilv_i = 1'b0;
      @(negedge clk);
      start_i = 1'b0; stop_i = 1'b0;
      expect_beats("R9", 8'h80, 1, 1'b0, 2);
      expect_idle("R9");
   endtask

   initial begin
      t_reset();
      t_lengths();
      t_sequential();
      t_interleaved();
      t_full_page();
      t_stop();
      t_restart();
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual hung, expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

endmodule